// File: doc/BRIEF.md
# Buffered Modulus Counter Timer

This block is the counting core of a timer channel whose period comes from a double-buffered modulus. Software may write a new modulus into a staging register at any moment. The active modulus that the counter compares against takes the staged value only at the cycle boundary, so a period that is running is never cut short or stretched by a write that lands partway through it.

The counter has two modes. In up mode it counts from one up to the modulus and then wraps back to one. In up/down mode it climbs to the modulus and then descends back to one. In both modes, the clock in which the count equals one raises a one-clock load strobe. The staged value moves into the active register at the end of that clock, unless the update-hold input blocks it.

A sticky match flag reports when the count equals the active modulus. A policy input can also make the flag set at every cycle boundary. Software clears the flag with a one-clock clear input.

Top module: `modbuf_timer`

## Requirements
- R1: While `rst` is high at a clock edge, `count` becomes 1, `modulus` becomes 1, the staging value becomes 1 and `flag` becomes 0.
- R2: With `mode_updown`=0, a clock where `count` is at least `modulus` is followed by `count`=1. Any other clock is followed by `count`+1.
- R3: With `mode_updown`=1, the count climbs by one per clock to `modulus` and then falls by one per clock to 1. From 1 it goes to 2, unless `modulus` is 1.
- R4: In any clock where `count`=1 and `upd_hold`=0, the staging value is copied into `modulus` at the end of that clock. During that clock, `modulus` still shows the old value.
- R5: A `stage_we` pulse during a cycle sets the modulus of the next cycle. If the write falls on the same edge as a load, that load takes the earlier staging value, and the newly written value waits for the following boundary.
- R6: While `upd_hold`=1, `modulus` keeps its value through boundaries, and the staging value is kept for later.
- R7: `flag` is set one clock after a clock where `count` equals `modulus`. With `mode_edge_flag`=1, it is also set one clock after any clock where `count`=1.
- R8: `flag` stays at 1 until a `flag_clr` pulse clears it. If a set event and `flag_clr` occur in the same clock, the flag ends up at 1.
- R9: When `modulus` is 1, `count` stays at 1 and a match occurs on every clock, in either mode.
- R10: Writing 0 to the staging register stores 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| stage_we | input | 1 | Write strobe for the staging modulus |
| stage_data | input | CW | Value written to the staging modulus |
| mode_updown | input | 1 | 0: up counter with wrap; 1: up/down counter |
| mode_edge_flag | input | 1 | 1: also set the flag at each cycle boundary |
| upd_hold | input | 1 | 1: block the staging-to-active transfer |
| flag_clr | input | 1 | Clears the sticky flag |
| count | output | CW | Current counter value |
| modulus | output | CW | Active modulus |
| flag | output | 1 | Sticky match/boundary flag |

## Verification
The bench aims writes at the exact edge of the load strobe. A design that sampled the new write there would change period one cycle early. It also holds updates off across several boundaries, where a leaky hold would let the period drift to the staged value. Clear pulses are placed on the same clock as match events, and a design that lets the clear win drops a flag. Modulus values of one and zero are driven in both modes to catch a counter that runs away past the modulus, and up/down periods as short as two catch a turnaround that is off by one.

// File: rtl/modbuf_pkg.sv
package modbuf_pkg;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_t;

  typedef struct packed {
    logic updown;
    logic edge_flag;
  } mode_t;

endpackage

// File: rtl/modbuf_modreg.sv
module modbuf_modreg #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [CW-1:0] wdata,
  input  logic          load,
  input  logic          hold,
  output logic [CW-1:0] active
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] staging;
  logic [CW-1:0] wval;

  assign wval = (wdata == '0) ? ONE : wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      staging <= ONE;
    end else if (we) begin
      staging <= wval;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= ONE;
    end else if (load && !hold) begin
      active <= staging;
    end
  end

  assert_load_copies_R4: assert property (@(posedge clk) disable iff (rst)
    (load && !hold) |=> (active == $past(staging)));

  assert_hold_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(active));

  assert_no_midcycle_change_R5: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(active));

  assert_never_zero_R10: assert property (@(posedge clk) disable iff (rst)
    we |=> (staging != '0));

endmodule

// File: rtl/modbuf_counter.sv
module modbuf_counter
  import modbuf_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          updown,
  input  logic [CW-1:0] modv,
  output logic [CW-1:0] cnt,
  output logic          at_one,
  output logic          match
);

  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TWO = CW'(2);

  dir_t          dir, dir_nx;
  logic [CW-1:0] cnt_nx;
  logic          at_top;

  assign at_one = (cnt == ONE);
  assign at_top = (cnt >= modv);
  assign match  = (cnt == modv);

  always_comb begin
    cnt_nx = cnt;
    dir_nx = dir;
    if (!updown) begin
      dir_nx = DIR_UP;
      cnt_nx = at_top ? ONE : cnt + ONE;
    end else if (at_one) begin
      dir_nx = DIR_UP;
      cnt_nx = (modv > ONE) ? TWO : ONE;
    end else if (dir == DIR_UP) begin
      if (at_top) begin
        dir_nx = DIR_DOWN;
        cnt_nx = cnt - ONE;
      end else begin
        cnt_nx = cnt + ONE;
      end
    end else begin
      cnt_nx = cnt - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= ONE;
      dir <= DIR_UP;
    end else begin
      cnt <= cnt_nx;
      dir <= dir_nx;
    end
  end

  assert_cnt_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    cnt != '0);

  assert_up_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (!updown && (cnt >= modv)) |=> (cnt == ONE));

  assert_down_step_R3: assert property (@(posedge clk) disable iff (rst)
    (updown && dir == DIR_DOWN && !at_one) |=> (cnt == $past(cnt) - ONE));

  assert_unit_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (at_one && modv == ONE) |=> (cnt == ONE));

endmodule

// File: rtl/modbuf_flag.sv
module modbuf_flag (
  input  logic clk,
  input  logic rst,
  input  logic match,
  input  logic at_one,
  input  logic edge_flag,
  input  logic clr,
  output logic flag
);

  logic set_evt;

  assign set_evt = match || (edge_flag && at_one);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (set_evt) begin
      flag <= 1'b1;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> flag);

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (clr && !set_evt) |=> !flag);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);

  assert_boundary_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (edge_flag && at_one) |=> flag);

endmodule

// File: rtl/modbuf_timer.sv
module modbuf_timer
  import modbuf_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stage_we,
  input  logic [CW-1:0] stage_data,
  input  logic          mode_updown,
  input  logic          mode_edge_flag,
  input  logic          upd_hold,
  input  logic          flag_clr,
  output logic [CW-1:0] count,
  output logic [CW-1:0] modulus,
  output logic          flag
);

  mode_t mode;
  logic  at_one;
  logic  match;

  assign mode.updown    = mode_updown;
  assign mode.edge_flag = mode_edge_flag;

  modbuf_modreg #(.CW(CW)) u_modreg (
    .clk   (clk),
    .rst   (rst),
    .we    (stage_we),
    .wdata (stage_data),
    .load  (at_one),
    .hold  (upd_hold),
    .active(modulus)
  );

  modbuf_counter #(.CW(CW)) u_counter (
    .clk   (clk),
    .rst   (rst),
    .updown(mode.updown),
    .modv  (modulus),
    .cnt   (count),
    .at_one(at_one),
    .match (match)
  );

  modbuf_flag u_flag (
    .clk      (clk),
    .rst      (rst),
    .match    (match),
    .at_one   (at_one),
    .edge_flag(mode.edge_flag),
    .clr      (flag_clr),
    .flag     (flag)
  );

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (count == CW'(1) && modulus == CW'(1) && !flag));

  assert_match_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (count == modulus) |=> flag);

endmodule

// File: tb/sim_modbuf_timer.sv
module sim_modbuf_timer;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          stage_we = 1'b0;
  logic [CW-1:0] stage_data = '0;
  logic          mode_updown = 1'b0;
  logic          mode_edge_flag = 1'b0;
  logic          upd_hold = 1'b0;
  logic          flag_clr = 1'b0;
  logic [CW-1:0] count;
  logic [CW-1:0] modulus;
  logic          flag;

  always #4 clk = ~clk;

  modbuf_timer #(.CW(CW)) u0 (
    .clk(clk), .rst(rst), .stage_we(stage_we), .stage_data(stage_data),
    .mode_updown(mode_updown), .mode_edge_flag(mode_edge_flag),
    .upd_hold(upd_hold), .flag_clr(flag_clr),
    .count(count), .modulus(modulus), .flag(flag)
  );

  int    nvec = 0;
  int    nbad = 0;
  int    cyc  = 0;
  string ph   = "R1";

  // Behavioural reference state
  int m_cnt = 1, m_act = 1, m_stg = 1, m_flag = 0, m_down = 0;

  always @(posedge clk) begin
    int ev, nc, nd, na, ns, nf;
    cyc = cyc + 1;
    if (rst) begin
      m_cnt = 1; m_act = 1; m_stg = 1; m_flag = 0; m_down = 0;
    end else begin
      ev = (m_cnt == m_act) || (mode_edge_flag && m_cnt == 1);
      nf = ev ? 1 : (flag_clr ? 0 : m_flag);
      nd = m_down;
      if (!mode_updown) begin
        nd = 0;
        nc = (m_cnt >= m_act) ? 1 : m_cnt + 1;
      end else if (m_cnt == 1) begin
        nd = 0;
        nc = (m_act > 1) ? 2 : 1;
      end else if (!m_down) begin
        if (m_cnt >= m_act) begin nd = 1; nc = m_cnt - 1; end
        else nc = m_cnt + 1;
      end else begin
        nc = m_cnt - 1;
      end
      na = (m_cnt == 1 && !upd_hold) ? m_stg : m_act;
      ns = stage_we ? ((stage_data == 0) ? 1 : int'(stage_data)) : m_stg;
      m_cnt = nc; m_down = nd; m_act = na; m_stg = ns; m_flag = nf;
    end
  end

  task automatic chk(string what, int act, int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", ph, what, act, exp, $time);
    end
  endtask

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    chk("count", int'(count), m_cnt);
    chk("modulus", int'(modulus), m_act);
    chk("flag", int'(flag), m_flag);
  end

  task automatic run(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(int v);
    stage_we = 1'b1; stage_data = CW'(v);
    @(negedge clk);
    stage_we = 1'b0;
  endtask

  task automatic wait_one();
    for (int i = 0; i < 200; i++) begin
      if (count == CW'(1)) break;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    // R1: reset state
    run(3);
    ph = "R1";
    chk("count@reset", int'(count), 1);
    chk("modulus@reset", int'(modulus), 1);
    chk("flag@reset", int'(flag), 0);
    rst = 1'b0;
    // R9: modulus one holds count at one, match each clock
    ph = "R9";
    run(4);
    chk("count@unit", int'(count), 1);
    chk("flag@unit", int'(flag), 1);
    // R2 / R4: up mode with mid-cycle write
    ph = "R2";
    wr(5);
    run(3);
    ph = "R4";
    wait_one();
    chk("modulus_old_during_load", int'(modulus), m_act);
    run(1);
    chk("modulus_after_load", int'(modulus), 5);
    ph = "R2";
    run(14);
    // R5: write landing on the load edge waits a boundary
    ph = "R5";
    run(2);
    wait_one();
    wr(3);
    chk("modulus_keeps_old_on_same_edge", int'(modulus), 5);
    run(12);
    chk("modulus_after_next_boundary", int'(modulus), 3);
    wr(7); run(2); wr(4);
    run(20);
    // R6: hold blocks transfer
    ph = "R6";
    upd_hold = 1'b1;
    wr(6);
    run(25);
    chk("modulus_held", int'(modulus), 4);
    upd_hold = 1'b0;
    run(16);
    // R7 / R8: boundary flags and clear collisions
    ph = "R7";
    mode_edge_flag = 1'b1;
    run(12);
    ph = "R8";
    for (int i = 0; i < 40; i++) begin
      flag_clr = (i % 3 != 2);
      @(negedge clk);
    end
    flag_clr = 1'b0;
    mode_edge_flag = 1'b0;
    for (int i = 0; i < 30; i++) begin
      flag_clr = (i % 2 == 0);
      @(negedge clk);
    end
    flag_clr = 1'b0;
    // R3: up/down mode
    ph = "R3";
    wait_one();
    mode_updown = 1'b1;
    run(30);
    wr(2); run(20);
    wr(8); run(40);
    for (int i = 0; i < 20; i++) begin
      flag_clr = (i % 4 == 1);
      @(negedge clk);
    end
    flag_clr = 1'b0;
    // R10 / R9: zero write acts as one, in up/down mode
    ph = "R10";
    wr(0);
    run(20);
    chk("modulus_from_zero", int'(modulus), 1);
    chk("count_unit_ud", int'(count), 1);
    ph = "R9";
    flag_clr = 1'b1; run(5); flag_clr = 1'b0;
    chk("flag_unit_ud", int'(flag), 1);
    // back to up mode with a short period
    ph = "R2";
    mode_updown = 1'b0;
    wr(2); run(20);
    wr(0); run(10);
    summary();
  end

  initial begin
    wait (cyc > 20000);
    nvec++; nbad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
    summary();
  end

endmodule